// File: doc/BRIEF.md
# Addressed I2C Target with Event Flags

This block lets an on-chip processor answer as a target on a two-wire I2C bus. Software programs one 7-bit own address into a small register window. The block then watches the bus for START and STOP conditions. It decodes the address byte and the direction bit, and it shifts data bytes in and out. Each bus event sets a sticky flag in a status register. An enable register with the same bit layout selects which flags raise the interrupt line.

Received bytes and bytes to transmit share one data port. While software has not yet read the last received byte, the block holds SCL low. It does the same while software has not yet supplied the next byte to send. A control bit makes the block answer received bytes with NACK. A second control bit lets it also accept the general call address.

The register window is a single-cycle synchronous bus: select, write, offset and write data go in, and read data comes out combinationally. The bus lines are open-drain. The block sees the wired level on `scl_in` and `sda_in`, and it pulls a line low through `scl_low_o` or `sda_low_o`.

Top module: `i2c_sl_responder`

## Requirements
- R1: After reset the status (offset 0x08), control (0x00) and interrupt enable (0x10) registers read 0, `irq_o` is low, and neither bus line is pulled low.
- R2: When the 8-bit address frame that follows a START carries the own address (offset 0x1C, bits 6:0) in its upper seven bits, the block pulls SDA low during the ninth clock and sets status bit 0. When the address does not match, the block leaves SDA released and sets no flag.
- R3: Status bit 5 follows the direction bit of the matched frame, with 1 meaning the controller reads. Writes to this bit have no effect.
- R4: With control bit 1 set, the frame 0x00 is acknowledged and sets status bits 6 and 0. With control bit 1 clear, the frame 0x00 is not acknowledged.
- R5: A completed received byte sets status bit 1 and can be read at offset 0x24. After the eighth clock, SCL is held low until software reads that offset, and the byte is then acknowledged.
- R6: When control bit 0 is set as software reads a received byte, that byte is answered with NACK. The block then ignores further bytes, pulling neither line, until the next START or STOP.
- R7: In read direction the block sets status bit 3 whenever it needs a byte. It holds SCL low until software writes offset 0x24, then shifts the byte out MSB first. It sets status bit 2 at the controller's acknowledge clock.
- R8: A STOP after a matched address sets status bit 4, clears status bit 5 and returns the block to waiting for an address.
- R9: A write to the status register clears each flag written as 0 and leaves each flag written as 1 unchanged.
- R10: `irq_o` is high exactly when some status flag is set whose bit in the enable register (same layout) is also set.
- R11: With control bit 2 (target enable) clear, the block ignores the bus: no acknowledge, no flags, no line pulled low.
- R12: The block changes its SDA drive only while SCL is low, and it starts holding SCL only after the controller has driven SCL low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected offset |
| scl_in | input | 1 | Wired SCL level seen on the bus |
| sda_in | input | 1 | Wired SDA level seen on the bus |
| scl_low_o | output | 1 | Pull SCL low (clock hold) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge or data 0) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets several hazards.
- A byte that arrives while the previous one is unread must hold SCL until the read. If the design released SCL early, the controller would sample an acknowledge that software never agreed to.
- The forced NACK must be taken when the data port is read, and the following bytes must then be ignored. A design that got this wrong would acknowledge a byte software rejected, or would hold SCL on a transfer it no longer serves.
- In read direction the first bit has to be on SDA before SCL is released. The acknowledge from the controller has to decide between fetching another byte and going silent. A mistake here shows up as a corrupted MSB or a hung bus.
- The bench also checks that a mismatched or general-call address with the enable clear leaves the status register untouched, including at the STOP.

// File: rtl/i2c_sl_pkg.sv
package i2c_sl_pkg;

  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h08;
  localparam logic [5:0] OFS_IEN  = 6'h10;
  localparam logic [5:0] OFS_OWN  = 6'h1C;
  localparam logic [5:0] OFS_DATA = 6'h24;

  localparam int CB_NACK   = 0;
  localparam int CB_GCEN   = 1;
  localparam int CB_ENA    = 2;
  localparam int CB_BUFSEL = 3;

  localparam int SB_ADDR  = 0;
  localparam int SB_RX    = 1;
  localparam int SB_SENT  = 2;
  localparam int SB_EMPTY = 3;
  localparam int SB_STOP  = 4;
  localparam int SB_TXM   = 5;
  localparam int SB_GC    = 6;

  localparam logic [7:0] STAT_STORE = 8'h5F;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK_WAIT, ST_AACK_DRV,
    ST_RX, ST_RACK_WAIT, ST_RHOLD, ST_RACK_DRV,
    ST_TX, ST_TACK, ST_IGNORE
  } sl_state_e;

  typedef struct packed {
    logic gc;
    logic stop;
    logic empty;
    logic sent;
    logic rx;
    logic addr;
  } sl_events_t;

  // {accept, general_call}
  function automatic logic [1:0] addr_check(input logic [7:0] frame,
                                            input logic [6:0] own,
                                            input logic       gc_en);
    logic hit, gc;
    hit = (frame[7:1] == own);
    gc  = gc_en && (frame == 8'h00);
    return {hit | gc, gc};
  endfunction

  function automatic logic [7:0] status_next(input logic [7:0] cur,
                                             input logic       wr,
                                             input logic [7:0] wdata,
                                             input logic [7:0] set);
    logic [7:0] kept;
    kept = wr ? (cur & wdata) : cur;
    return (kept | set) & STAT_STORE;
  endfunction

  function automatic logic [7:0] event_vector(input sl_events_t ev);
    logic [7:0] v;
    v = 8'h00;
    v[SB_ADDR]  = ev.addr;
    v[SB_RX]    = ev.rx;
    v[SB_SENT]  = ev.sent;
    v[SB_EMPTY] = ev.empty;
    v[SB_STOP]  = ev.stop;
    v[SB_GC]    = ev.gc;
    return v;
  endfunction

endpackage

// File: rtl/i2c_sl_linesync.sv
module i2c_sl_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_in;
          sda_sh <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_in};
          sda_sh <= {sda_sh[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_sh[STAGES-1];
      sda_d <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_sl_regs.sv
module i2c_sl_regs
  import i2c_sl_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  sl_events_t    ev,
  input  logic          tx_mode,
  input  logic [7:0]    rx_byte,
  input  logic          tx_take,
  output logic          ena,
  output logic          gc_en,
  output logic          force_nack,
  output logic [6:0]    own_addr,
  output logic [7:0]    tx_buf,
  output logic          tx_full,
  output logic          rx_read,
  output logic [7:0]    status_rd,
  output logic          irq
);
  logic [3:0] ctrl_q;
  logic [6:0] ien_q;
  logic [6:0] own_q;
  logic [7:0] stat_q;
  logic [7:0] txb_q;
  logic       txf_q;
  logic       wr_ctrl, wr_stat, wr_ien, wr_own, wr_data;

  assign wr_ctrl = bus_sel & bus_wr & (bus_addr == AW'(OFS_CTRL));
  assign wr_stat = bus_sel & bus_wr & (bus_addr == AW'(OFS_STAT));
  assign wr_ien  = bus_sel & bus_wr & (bus_addr == AW'(OFS_IEN));
  assign wr_own  = bus_sel & bus_wr & (bus_addr == AW'(OFS_OWN));
  assign wr_data = bus_sel & bus_wr & (bus_addr == AW'(OFS_DATA));
  assign rx_read = bus_sel & ~bus_wr & (bus_addr == AW'(OFS_DATA));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      own_q  <= '0;
      stat_q <= '0;
      txb_q  <= '0;
      txf_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[3:0];
      if (wr_ien)  ien_q  <= bus_wdata[6:0];
      if (wr_own)  own_q  <= bus_wdata[6:0];
      stat_q <= status_next(stat_q, wr_stat, bus_wdata, event_vector(ev));
      if (tx_take) txf_q <= 1'b0;
      if (wr_data) begin
        txb_q <= bus_wdata;
        txf_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_rd         = stat_q;
    status_rd[SB_TXM] = tx_mode;
  end

  always_comb begin
    case (bus_addr)
      AW'(OFS_CTRL): bus_rdata = {4'b0, ctrl_q};
      AW'(OFS_STAT): bus_rdata = status_rd;
      AW'(OFS_IEN):  bus_rdata = {1'b0, ien_q};
      AW'(OFS_OWN):  bus_rdata = {1'b0, own_q};
      AW'(OFS_DATA): bus_rdata = rx_byte;
      default:       bus_rdata = 8'h00;
    endcase
  end

  assign ena        = ctrl_q[CB_ENA];
  assign gc_en      = ctrl_q[CB_GCEN];
  assign force_nack = ctrl_q[CB_NACK];
  assign own_addr   = own_q;
  assign tx_buf     = txb_q;
  assign tx_full    = txf_q;
  assign irq        = |(status_rd & {1'b0, ien_q});
endmodule

// File: rtl/i2c_sl_engine.sv
module i2c_sl_engine
  import i2c_sl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ena,
  input  logic       gc_en,
  input  logic       force_nack,
  input  logic [6:0] own_addr,
  input  logic [7:0] tx_buf,
  input  logic       tx_full,
  input  logic       rx_read,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output sl_events_t ev,
  output logic       tx_mode,
  output logic [7:0] rx_byte,
  output logic       tx_take,
  output logic       sda_low,
  output logic       scl_low,
  output logic       addressed
);
  sl_state_e  state_q;
  sl_events_t ev_q;
  logic [2:0] cnt_q;
  logic [7:0] sh_q, rxb_q;
  logic       txm_q, addr_q, unread_q, nack_q, loaded_q, ackok_q, hold_q, take_q;
  logic [7:0] frame_c;
  logic [1:0] chk_c;
  logic       stretch_c;

  assign frame_c   = {sh_q[6:0], sda_s};
  assign chk_c     = addr_check(frame_c, own_addr, gc_en);
  assign stretch_c = (state_q == ST_RHOLD) | ((state_q == ST_TX) & ~loaded_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ev_q     <= '0;
      cnt_q    <= '0;
      sh_q     <= '0;
      rxb_q    <= '0;
      txm_q    <= 1'b0;
      addr_q   <= 1'b0;
      unread_q <= 1'b0;
      nack_q   <= 1'b0;
      loaded_q <= 1'b0;
      ackok_q  <= 1'b0;
      hold_q   <= 1'b0;
      take_q   <= 1'b0;
    end else begin
      ev_q   <= '0;
      take_q <= 1'b0;
      hold_q <= stretch_c;
      if (rx_read) unread_q <= 1'b0;
      if (!ena) begin
        state_q <= ST_IDLE;
        addr_q  <= 1'b0;
        txm_q   <= 1'b0;
      end else if (stop_det) begin
        if (addr_q) ev_q.stop <= 1'b1;
        state_q <= ST_IDLE;
        addr_q  <= 1'b0;
        txm_q   <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_ADDR: if (scl_rise) begin
            sh_q <= frame_c;
            if (cnt_q == 3'd7) begin
              if (chk_c[1]) begin
                ev_q.addr <= 1'b1;
                ev_q.gc   <= chk_c[0];
                txm_q     <= frame_c[0];
                addr_q    <= 1'b1;
                state_q   <= ST_AACK_WAIT;
              end else begin
                addr_q  <= 1'b0;
                state_q <= ST_IGNORE;
              end
            end else begin
              cnt_q <= cnt_q + 3'd1;
            end
          end
          ST_AACK_WAIT: if (scl_fall) state_q <= ST_AACK_DRV;
          ST_AACK_DRV: if (scl_fall) begin
            cnt_q <= '0;
            if (txm_q) begin
              state_q    <= ST_TX;
              loaded_q   <= 1'b0;
              ev_q.empty <= 1'b1;
            end else begin
              state_q <= ST_RX;
            end
          end
          ST_RX: if (scl_rise) begin
            sh_q <= frame_c;
            if (cnt_q == 3'd7) begin
              rxb_q    <= frame_c;
              ev_q.rx  <= 1'b1;
              unread_q <= 1'b1;
              state_q  <= ST_RACK_WAIT;
            end else begin
              cnt_q <= cnt_q + 3'd1;
            end
          end
          ST_RACK_WAIT: if (scl_fall) state_q <= ST_RHOLD;
          ST_RHOLD: if (!unread_q) begin
            nack_q  <= force_nack;
            state_q <= ST_RACK_DRV;
          end
          ST_RACK_DRV: if (scl_fall) begin
            cnt_q   <= '0;
            state_q <= nack_q ? ST_IGNORE : ST_RX;
          end
          ST_TX: begin
            if (!loaded_q) begin
              if (tx_full) begin
                sh_q     <= tx_buf;
                loaded_q <= 1'b1;
                take_q   <= 1'b1;
              end
            end else if (scl_fall) begin
              if (cnt_q == 3'd7) begin
                state_q <= ST_TACK;
              end else begin
                sh_q  <= {sh_q[6:0], 1'b0};
                cnt_q <= cnt_q + 3'd1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              ackok_q   <= ~sda_s;
              ev_q.sent <= 1'b1;
            end else if (scl_fall) begin
              cnt_q <= '0;
              if (ackok_q) begin
                state_q    <= ST_TX;
                loaded_q   <= 1'b0;
                ev_q.empty <= 1'b1;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ev        = ev_q;
  assign tx_mode   = txm_q;
  assign rx_byte   = rxb_q;
  assign tx_take   = take_q;
  assign addressed = addr_q;
  assign scl_low   = stretch_c | hold_q;
  assign sda_low   = (state_q == ST_AACK_DRV)
                   | ((state_q == ST_RACK_DRV) & ~nack_q)
                   | ((state_q == ST_TX) & loaded_q & ~sh_q[7]);
endmodule

// File: rtl/i2c_sl_responder.sv
module i2c_sl_responder
  import i2c_sl_pkg::*;
#(
  parameter int BUS_AW      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              irq_o
);
  sl_events_t ev_w;
  logic       sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic       ena_w, gc_en_w, fnack_w, tx_full_w, rx_read_w, tx_take_w;
  logic       tx_mode_w, addressed_w;
  logic [6:0] own_w;
  logic [7:0] tx_buf_w, rx_byte_w, status_w;

  i2c_sl_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s_w), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_det(start_w), .stop_det(stop_w)
  );

  i2c_sl_regs #(.AW(BUS_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev(ev_w), .tx_mode(tx_mode_w), .rx_byte(rx_byte_w), .tx_take(tx_take_w),
    .ena(ena_w), .gc_en(gc_en_w), .force_nack(fnack_w), .own_addr(own_w),
    .tx_buf(tx_buf_w), .tx_full(tx_full_w), .rx_read(rx_read_w),
    .status_rd(status_w), .irq(irq_o)
  );

  i2c_sl_engine u_eng (
    .clk(clk), .rst_n(rst_n), .ena(ena_w), .gc_en(gc_en_w),
    .force_nack(fnack_w), .own_addr(own_w), .tx_buf(tx_buf_w),
    .tx_full(tx_full_w), .rx_read(rx_read_w), .sda_s(sda_s_w),
    .scl_rise(scl_rise_w), .scl_fall(scl_fall_w), .start_det(start_w),
    .stop_det(stop_w), .ev(ev_w), .tx_mode(tx_mode_w), .rx_byte(rx_byte_w),
    .tx_take(tx_take_w), .sda_low(sda_low_o), .scl_low(scl_low_o),
    .addressed(addressed_w)
  );
endmodule

// File: rtl/i2c_sl_checker.sv
module i2c_sl_checker
  import i2c_sl_pkg::*;
#(
  parameter int BUS_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ena,
  input logic              scl_in,
  input logic              sda_low,
  input logic              scl_low,
  input logic              addressed,
  input logic              ev_stop,
  input logic              ev_addr,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        status
);
  // R11: a disabled target drives nothing
  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena && $past(!ena)) |=> (!sda_low && !scl_low));

  // R12: SDA drive moves only while SCL is low
  a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ena && $past(ena) && !$stable(sda_low)) |-> !scl_in);

  // R5, R7: clock hold only inside an addressed transfer
  a_r5_hold_when_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low) |-> addressed);

  // R8: a STOP leaves both lines released
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |-> (!sda_low && !scl_low && !addressed));

  // R9: writing 0 to the address flag clears it
  a_r9_write_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == BUS_AW'(OFS_STAT) && !bus_wdata[SB_ADDR] && !ev_addr)
    |=> !status[SB_ADDR]);
endmodule

bind i2c_sl_responder i2c_sl_checker #(.BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ena(ena_w), .scl_in(scl_in),
  .sda_low(sda_low_o), .scl_low(scl_low_o), .addressed(addressed_w),
  .ev_stop(ev_w.stop), .ev_addr(ev_w.addr), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .status(status_w)
);

// File: tb/tb_i2c_sl_responder.sv
module tb_i2c_sl_responder;
  localparam int Q = 20;
  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h08, A_IEN = 6'h10,
                         A_OWN = 6'h1C, A_DATA = 6'h24;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_low, sda_low, irq;
  wire        scl_line = scl_m & ~scl_low;
  wire        sda_line = sda_m & ~sda_low;

  int n_chk = 0, n_fail = 0;
  int r12_bad = 0, hold_bad = 0;
  logic sda_low_p = 1'b0, scl_low_p = 1'b0;

  i2c_sl_responder dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scl_in(scl_line), .sda_in(sda_line), .scl_low_o(scl_low),
    .sda_low_o(sda_low), .irq_o(irq)
  );

  // per-clock model of the line rules (R12)
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_low !== sda_low_p && scl_line) r12_bad++;
      if (scl_low && !scl_low_p && scl_m) hold_bad++;
    end
    sda_low_p = sda_low;
    scl_low_p = scl_low;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic scl_up;
    scl_m = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; scl_m = 1'b1; wq;
    sda_m = 1'b0; wq;
    scl_m = 1'b0; wq;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wq;
    scl_up; wq;
    sda_m = 1'b1; wq;
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq;
    scl_up; wq;
    scl_m = 1'b0; wq;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq;
    scl_up; wq;
    b = sda_line;
    scl_m = 1'b0; wq;
  endtask

  task automatic byte_out(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic byte_in(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
  endtask

  // receive one byte with software reading it during the clock hold
  task automatic rx_byte_sw(input logic [7:0] v, input string req, output logic ack);
    logic [7:0] st, d;
    byte_out(v);
    fork
      bit_in(ack);
      begin
        repeat (60) @(negedge clk);
        check({req, " R5 SCL held until read"}, scl_low, 1'b1);
        bus_read(A_STAT, st);
        check({req, " R5 data-received flag"}, st[1], 1'b1);
        bus_read(A_DATA, d);
        check({req, " R5 received byte"}, d, v);
      end
    join
  endtask

  // transmit one byte that software supplies during the clock hold
  task automatic tx_byte_sw(input logic [7:0] v, output logic [7:0] got);
    fork
      byte_in(got);
      begin
        repeat (60) @(negedge clk);
        check("R7 SCL held until data written", scl_low, 1'b1);
        bus_write(A_DATA, v);
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r, got;
    logic       ack;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_STAT, r); check("R1 status after reset", r, 8'h00);
    bus_read(A_CTRL, r); check("R1 control after reset", r, 8'h00);
    bus_read(A_IEN, r);  check("R1 irq enable after reset", r, 8'h00);
    check("R1 irq low", irq, 1'b0);
    check("R1 lines released", {scl_low, sda_low}, 2'b00);

    bus_write(A_OWN, {1'b0, OWN});
    bus_write(A_CTRL, 8'h04);

    // R2 mismatched address
    i2c_start; byte_out({7'h50, 1'b0}); bit_in(ack);
    check("R2 mismatch not acknowledged", ack, 1'b1);
    i2c_stop;
    bus_read(A_STAT, r); check("R2 mismatch sets no flag", r, 8'h00);

    // R2/R3/R5/R9/R8 write transfer
    i2c_start; byte_out({OWN, 1'b0}); bit_in(ack);
    check("R2 own address acknowledged", ack, 1'b0);
    bus_read(A_STAT, r); check("R2 R3 address flag, write direction", r, 8'h01);
    rx_byte_sw(8'hA5, "byte1", ack);
    check("R5 byte1 acknowledged after read", ack, 1'b0);
    bus_read(A_STAT, r); check("R5 status after byte1", r, 8'h03);
    bus_write(A_STAT, 8'hFE);
    bus_read(A_STAT, r); check("R9 write 0 clears, 1 keeps", r, 8'h02);
    rx_byte_sw(8'h3C, "byte2", ack);
    check("R5 byte2 acknowledged", ack, 1'b0);
    i2c_stop;
    bus_read(A_STAT, r); check("R8 stop flag set", r, 8'h12);

    // R10 interrupt masking
    bus_write(A_IEN, 8'h10); @(negedge clk);
    check("R10 enabled flag raises irq", irq, 1'b1);
    bus_write(A_IEN, 8'h01); @(negedge clk);
    check("R10 masked flags keep irq low", irq, 1'b0);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, r); check("R9 clear all", r, 8'h00);

    // R6 forced NACK
    bus_write(A_CTRL, 8'h05);
    i2c_start; byte_out({OWN, 1'b0}); bit_in(ack);
    check("R6 address still acknowledged", ack, 1'b0);
    rx_byte_sw(8'h77, "nackbyte", ack);
    check("R6 forced NACK on byte", ack, 1'b1);
    bus_write(A_STAT, 8'h00);
    byte_out(8'h11); bit_in(ack);
    check("R6 following byte ignored", ack, 1'b1);
    bus_read(A_STAT, r); check("R6 no receive flag after NACK", r[1], 1'b0);
    i2c_stop;
    bus_write(A_CTRL, 8'h04);
    bus_write(A_STAT, 8'h00);

    // R3/R7/R8 read transfer
    i2c_start; byte_out({OWN, 1'b1}); bit_in(ack);
    check("R3 read address acknowledged", ack, 1'b0);
    repeat (30) @(negedge clk);
    bus_read(A_STAT, r); check("R3 R7 transmit mode and data-empty", r, 8'h29);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, r); check("R3 transmit mode not writable", r, 8'h20);
    tx_byte_sw(8'hC3, got);
    check("R7 first byte MSB first", got, 8'hC3);
    bit_out(1'b0);
    repeat (30) @(negedge clk);
    bus_read(A_STAT, r); check("R7 sent and empty after ACK", r, 8'h2C);
    bus_write(A_STAT, 8'h00);
    tx_byte_sw(8'h5A, got);
    check("R7 second byte", got, 8'h5A);
    bit_out(1'b1);
    bus_read(A_STAT, r); check("R7 sent flag on NACK", r, 8'h24);
    i2c_stop;
    bus_read(A_STAT, r); check("R8 stop clears transmit mode", r, 8'h14);
    bus_write(A_STAT, 8'h00);

    // R4 general call
    i2c_start; byte_out(8'h00); bit_in(ack);
    check("R4 general call refused when disabled", ack, 1'b1);
    i2c_stop;
    bus_write(A_CTRL, 8'h06);
    i2c_start; byte_out(8'h00); bit_in(ack);
    check("R4 general call acknowledged", ack, 1'b0);
    bus_read(A_STAT, r); check("R4 general call flags", r, 8'h41);
    i2c_stop;
    bus_write(A_STAT, 8'h00);

    // R11 disabled target
    bus_write(A_CTRL, 8'h00);
    i2c_start; byte_out({OWN, 1'b0}); bit_in(ack);
    check("R11 disabled target silent", ack, 1'b1);
    i2c_stop;
    bus_read(A_STAT, r); check("R11 no flags while disabled", r, 8'h00);

    check("R12 SDA changed while SCL high", r12_bad, 0);
    check("R12 hold began with SCL high", hold_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule